// File: doc/BRIEF.md
# External Interrupt Edge and Wake Controller

This block watches a set of external interrupt pins and turns their transitions into per-channel request flags. Each channel has a two-bit mode field in one control register. The field selects one of four modes: no detection, rising edge, falling edge, or either edge. In run mode the pins pass through a multi-flop synchroniser, and an edge that matches the mode sets the channel's flag. A flag with its channel enable set raises a service request toward the processor. Software clears flags through a clear input.

The same mode field also controls power-down. When a power-down request arrives, the block refuses it if any channel already sits at its exit level. Otherwise it stops the clocks. While stopped, the raw pin levels are qualified over a programmable number of consecutive samples. The first qualified exit level produces a wake pulse and sets the flags of the waking channels, whatever their enables are. A stabilisation counter then holds the clocks off for a programmed number of cycles before run mode resumes.

Top module: `exint_wake_ctrl`

## Requirements
- R1: The control register resets to 0x0000, is loaded from `cfg_wdata` on a cycle with `cfg_we` high, and is visible on `cfg_rdata`. Channel x is controlled by bits [2x+1:2x].
- R2: Mode code 00 never sets the channel's flag. The channel's pin has no effect on power-down entry or exit.
- R3: In run mode, code 01 sets the flag on a rising pin edge, code 10 on a falling edge, and code 11 on either edge. The flag is set on the third rising clock edge after the raw pin change.
- R4: A power-down request is refused, and `clk_run` stays high, when a channel with code 01 has its synchronised pin high or a channel with code 10 has it low. Code 11 channels never cause a refusal.
- R5: While powered down, a channel is at its wake level when its raw pin is high (code 01), low (code 10), or different from the level sampled at entry (code 11). Wake fires only after MIN_WAKE consecutive cycles at a wake level. A shorter pulse leaves the block powered down.
- R6: On wake, `wake` pulses for one cycle and the flag of each channel at its wake level is set, whatever its `irq_en` bit is.
- R7: After the wake pulse, `clk_run` stays low for `pd_delay`+1 cycles and then rises. `svc_req` is all zero while `clk_run` is low.
- R8: While running, `svc_req[x]` is high exactly when the flag and `irq_en[x]` are both high. A flag whose enable is clear stays set until `flag_clr[x]` clears it.
- R9: When a flag set event and `flag_clr` for the same channel fall in the same cycle, the flag ends up set.
- R10: No edge flag is set while the clocks are stopped, including during a rejected short wake pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control register write data |
| cfg_rdata | output | 16 | Control register contents |
| pin_raw | input | 8 | Asynchronous external interrupt pins |
| irq_en | input | 8 | Per-channel interrupt enables |
| pd_req | input | 1 | Power-down request pulse |
| pd_delay | input | 8 | Stabilisation delay after wake, in cycles minus one |
| flag_clr | input | 8 | Per-channel software flag clear |
| req_flag | output | 8 | Per-channel request flags |
| svc_req | output | 8 | Per-channel interrupt service requests |
| wake | output | 1 | One-cycle pulse when a wake is accepted |
| clk_run | output | 1 | High while the clocks run (run mode) |

## Verification
A detected edge and a software flag clear can reach the same channel on the same clock edge. The bench times the clear pulse so that it covers exactly the edge on which the synchronised rising edge lands, and then expects the flag to read as set (R9). A clear issued alone in a later cycle must then drop the flag, which shows that the clear path works on its own.

// File: rtl/exw_pkg.sv
package exw_pkg;

   typedef enum logic [1:0] {
      EXW_OFF  = 2'b00,
      EXW_RISE = 2'b01,
      EXW_FALL = 2'b10,
      EXW_ANY  = 2'b11
   } exw_mode_e;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_PD   = 2'd1,
      ST_STAB = 2'd2
   } exw_state_e;

endpackage

// File: rtl/exw_sync.sv
module exw_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '0;
      else        stage_q[0] <= din;
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[k] <= '0;
         else        stage_q[k] <= stage_q[k-1];
      end
   end

   assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/exw_chan.sv
module exw_chan
   import exw_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  exw_mode_e mode,
   input  logic      pin_s,
   input  logic      pin_raw,
   input  logic      run,
   input  logic      pd_enter,
   input  logic      wake_fire,
   input  logic      flag_clr,
   output logic      flag,
   output logic      exit_lvl,
   output logic      wake_lvl
);

   logic prev_q;
   logic snap_q;
   logic rise;
   logic fall;
   logic edge_hit;
   logic set_ev;

   assign rise = pin_s & ~prev_q;
   assign fall = ~pin_s & prev_q;

   always_comb begin
      edge_hit = 1'b0;
      exit_lvl = 1'b0;
      wake_lvl = 1'b0;
      unique case (mode)
         EXW_RISE: begin
            edge_hit = rise;
            exit_lvl = pin_s;
            wake_lvl = pin_raw;
         end
         EXW_FALL: begin
            edge_hit = fall;
            exit_lvl = ~pin_s;
            wake_lvl = ~pin_raw;
         end
         EXW_ANY: begin
            edge_hit = rise | fall;
            exit_lvl = 1'b0;
            wake_lvl = pin_raw ^ snap_q;
         end
         default: begin
            edge_hit = 1'b0;
         end
      endcase
   end

   assign set_ev = (run & edge_hit) | (wake_fire & wake_lvl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         snap_q <= 1'b0;
         flag   <= 1'b0;
      end else begin
         prev_q <= pin_s;
         if (pd_enter) snap_q <= pin_s;
         if (set_ev)        flag <= 1'b1;
         else if (flag_clr) flag <= 1'b0;
      end
   end

   // R9: a set event beats a same-cycle clear
   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (set_ev && flag_clr) |=> flag);

   // R2: a disabled channel never raises its flag
   p_off_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == EXW_OFF && !flag) |=> !flag);

   // R10: without run mode or a wake commit the flag cannot rise
   p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wake_fire && !flag) |=> !flag);

endmodule

// File: rtl/exw_wake_fsm.sv
module exw_wake_fsm
   import exw_pkg::*;
#(
   parameter int MIN_WAKE = 4,
   parameter int STAB_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pd_req,
   input  logic              exit_any,
   input  logic              wake_any,
   input  logic [STAB_W-1:0] pd_delay,
   output logic              pd_enter,
   output logic              wake_fire,
   output logic              wake,
   output logic              clk_run
);

   localparam int              FW      = $clog2(MIN_WAKE + 1);
   localparam logic [FW-1:0]   FIRE_AT = FW'(MIN_WAKE - 1);

   exw_state_e        state;
   logic [FW-1:0]     fcnt;
   logic [STAB_W-1:0] scnt;

   assign clk_run   = (state == ST_RUN);
   assign pd_enter  = (state == ST_RUN) && pd_req && !exit_any;
   assign wake_fire = (state == ST_PD) && wake_any && (fcnt == FIRE_AT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_RUN;
         fcnt  <= '0;
         scnt  <= '0;
         wake  <= 1'b0;
      end else begin
         wake <= wake_fire;
         unique case (state)
            ST_RUN: begin
               fcnt <= '0;
               scnt <= '0;
               if (pd_enter) state <= ST_PD;
            end
            ST_PD: begin
               if (!wake_any) begin
                  fcnt <= '0;
               end else if (fcnt == FIRE_AT) begin
                  fcnt  <= '0;
                  state <= ST_STAB;
               end else begin
                  fcnt <= fcnt + 1'b1;
               end
            end
            ST_STAB: begin
               if (scnt == pd_delay) begin
                  scnt  <= '0;
                  state <= ST_RUN;
               end else begin
                  scnt <= scnt + 1'b1;
               end
            end
            default: state <= ST_RUN;
         endcase
      end
   end

   // R4: a request met by an exit level leaves run mode in place
   p_refuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && pd_req && exit_any) |=> state == ST_RUN);

   // R5: power-down persists while no channel shows a wake level
   p_filter_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PD && !wake_any) |=> state == ST_PD);

   // R6: a wake pulse only follows power-down
   p_wake_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> $past(state) == ST_PD);

   // R7: the stabilisation wait is not cut short
   p_stab_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STAB && scnt != pd_delay && $stable(pd_delay)) |=> state == ST_STAB);

endmodule

// File: rtl/exint_wake_ctrl.sv
module exint_wake_ctrl
   import exw_pkg::*;
#(
   parameter int N_CH        = 8,
   parameter int CFG_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int MIN_WAKE    = 4,
   parameter int STAB_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   input  logic [N_CH-1:0]   pin_raw,
   input  logic [N_CH-1:0]   irq_en,
   input  logic              pd_req,
   input  logic [STAB_W-1:0] pd_delay,
   input  logic [N_CH-1:0]   flag_clr,
   output logic [N_CH-1:0]   req_flag,
   output logic [N_CH-1:0]   svc_req,
   output logic              wake,
   output logic              clk_run
);

   localparam int FIELD_W = 2;

   if (CFG_W != FIELD_W * N_CH) begin : g_bad_width
      $error("CFG_W must hold one two-bit field per channel");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (MIN_WAKE < 1) begin : g_bad_wake
      $error("MIN_WAKE must be at least 1");
   end

   logic [CFG_W-1:0] cfg_q;
   logic [N_CH-1:0]  pin_s;
   logic [N_CH-1:0]  exit_lvl;
   logic [N_CH-1:0]  wake_lvl;
   logic             pd_enter;
   logic             wake_fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (cfg_we) cfg_q <= cfg_wdata;
   end
   assign cfg_rdata = cfg_q;

   exw_sync #(
      .WIDTH  (N_CH),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pin_raw),
      .dout  (pin_s)
   );

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      exw_chan u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .mode      (exw_mode_e'(cfg_q[FIELD_W*i +: FIELD_W])),
         .pin_s     (pin_s[i]),
         .pin_raw   (pin_raw[i]),
         .run       (clk_run),
         .pd_enter  (pd_enter),
         .wake_fire (wake_fire),
         .flag_clr  (flag_clr[i]),
         .flag      (req_flag[i]),
         .exit_lvl  (exit_lvl[i]),
         .wake_lvl  (wake_lvl[i])
      );
   end

   exw_wake_fsm #(
      .MIN_WAKE (MIN_WAKE),
      .STAB_W   (STAB_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .pd_req    (pd_req),
      .exit_any  (|exit_lvl),
      .wake_any  (|wake_lvl),
      .pd_delay  (pd_delay),
      .pd_enter  (pd_enter),
      .wake_fire (wake_fire),
      .wake      (wake),
      .clk_run   (clk_run)
   );

   assign svc_req = {N_CH{clk_run}} & req_flag & irq_en;

   // R1: the control register only moves on a write strobe
   p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(cfg_rdata));

endmodule

// File: tb/exint_wake_ctrl_bench.sv
module exint_wake_ctrl_bench;

   localparam int MINW  = 4;
   localparam int DELAY = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic [7:0]  pin_raw = '0;
   logic [7:0]  irq_en = '0;
   logic        pd_req = 1'b0;
   logic [7:0]  pd_delay = 8'(DELAY);
   logic [7:0]  flag_clr = '0;
   logic [7:0]  req_flag;
   logic [7:0]  svc_req;
   logic        wake;
   logic        clk_run;

   int checks = 0;
   int fails = 0;
   int wake_cnt = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   exint_wake_ctrl u_exint_wake_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .pin_raw(pin_raw), .irq_en(irq_en),
      .pd_req(pd_req), .pd_delay(pd_delay), .flag_clr(flag_clr),
      .req_flag(req_flag), .svc_req(svc_req), .wake(wake), .clk_run(clk_run)
   );

   always @(negedge clk) if (wake) wake_cnt++;

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         fails++;
         $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic write_cfg(input logic [15:0] v);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic clear_all;
      @(negedge clk);
      flag_clr = 8'hFF;
      @(negedge clk);
      flag_clr = 8'h00;
   endtask

   task automatic pulse_pd;
      @(negedge clk);
      pd_req = 1'b1;
      @(negedge clk);
      pd_req = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 reset cfg", 32'(cfg_rdata), 32'h0);
      chk("R1 reset flags", 32'(req_flag), 32'h0);
      chk("R7 reset clk_run", 32'(clk_run), 32'h1);
      chk("R8 reset svc", 32'(svc_req), 32'h0);
   endtask

   task automatic t_cfg_rw;
      write_cfg(16'hA5C3);
      chk("R1 readback", 32'(cfg_rdata), 32'hA5C3);
      write_cfg(16'h0000);
      chk("R1 readback zero", 32'(cfg_rdata), 32'h0);
   endtask

   // ch0 rise, ch1 fall, ch2 any, ch3 off
   task automatic t_edges;
      write_cfg(16'h0039);
      clear_all();
      @(negedge clk);
      pin_raw[3:0] = 4'hF;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      chk("R3 not yet after two edges", 32'(req_flag[3:0]), 32'h0);
      @(negedge clk);
      chk("R3 R2 rising pattern", 32'(req_flag[3:0]), 32'h5);
      clear_all();
      @(negedge clk);
      pin_raw[3:0] = 4'h0;
      wait_cyc(4);
      chk("R3 R2 falling pattern", 32'(req_flag[3:0]), 32'h6);
      clear_all();
      chk("R8 clear", 32'(req_flag), 32'h0);
   endtask

   task automatic t_set_clr;
      write_cfg(16'h0001);
      clear_all();
      irq_en = 8'h00;
      @(negedge clk);
      pin_raw[0] = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      flag_clr[0] = 1'b1;
      @(negedge clk);
      flag_clr[0] = 1'b0;
      chk("R9 set wins over clear", 32'(req_flag[0]), 32'h1);
      wait_cyc(5);
      chk("R8 flag held with enable clear", 32'(req_flag[0]), 32'h1);
      chk("R8 no svc with enable clear", 32'(svc_req[0]), 32'h0);
      irq_en[0] = 1'b1;
      @(negedge clk);
      chk("R8 svc with enable", 32'(svc_req), 32'h1);
      @(negedge clk);
      flag_clr[0] = 1'b1;
      @(negedge clk);
      flag_clr[0] = 1'b0;
      chk("R8 clear alone drops flag", 32'(req_flag[0]), 32'h0);
      irq_en = 8'h00;
      @(negedge clk);
      pin_raw[0] = 1'b0;
      wait_cyc(4);
   endtask

   task automatic t_refuse;
      clear_all();
      write_cfg(16'h0001);
      pin_raw[0] = 1'b1;
      wait_cyc(4);
      clear_all();
      pulse_pd();
      wait_cyc(2);
      chk("R4 refuse rise-mode high pin", 32'(clk_run), 32'h1);
      write_cfg(16'h0002);
      pin_raw[0] = 1'b0;
      wait_cyc(4);
      clear_all();
      pulse_pd();
      wait_cyc(2);
      chk("R4 refuse fall-mode low pin", 32'(clk_run), 32'h1);
      write_cfg(16'h0000);
      pin_raw[0] = 1'b1;
      wait_cyc(4);
      pulse_pd();
      wait_cyc(2);
      chk("R2 R4 off channel does not refuse", 32'(clk_run), 32'h0);
      pin_raw[0] = 1'b0;
      wait_cyc(8);
      chk("R2 off channel does not wake", 32'(clk_run), 32'h0);
      write_cfg(16'h0001);
      @(negedge clk);
      pin_raw[0] = 1'b1;
      wait_cyc(MINW + DELAY + 4);
      chk("R5 recover to run", 32'(clk_run), 32'h1);
      pin_raw[0] = 1'b0;
      wait_cyc(4);
      clear_all();
   endtask

   task automatic t_wake(input string nm, input logic [1:0] code,
                         input logic start_lvl, input logic wake_lvl, input logic en);
      int n;
      write_cfg({14'b0, code});
      pin_raw[0] = start_lvl;
      wait_cyc(5);
      clear_all();
      irq_en[0] = en;
      wake_cnt = 0;
      pulse_pd();
      @(negedge clk);
      chk({nm, " R4 entry accepted"}, 32'(clk_run), 32'h0);
      pin_raw[0] = wake_lvl;
      for (int k = 0; k < MINW - 1; k++) @(posedge clk);
      @(negedge clk);
      pin_raw[0] = start_lvl;
      wait_cyc(6);
      chk({nm, " R5 short pulse ignored"}, 32'(clk_run), 32'h0);
      chk({nm, " R5 no wake pulse"}, 32'(wake_cnt), 32'h0);
      chk({nm, " R10 no flag while stopped"}, 32'(req_flag), 32'h0);
      pin_raw[0] = wake_lvl;
      for (int k = 0; k < MINW - 1; k++) @(posedge clk);
      @(negedge clk);
      chk({nm, " R5 no wake before count"}, 32'(wake), 32'h0);
      @(negedge clk);
      chk({nm, " R6 wake pulse"}, 32'(wake), 32'h1);
      n = 0;
      while (!clk_run) begin
         if (svc_req !== 8'h00) chk({nm, " R7 svc during restart"}, 32'(svc_req), 32'h0);
         n++;
         @(negedge clk);
      end
      chk({nm, " R7 restart delay"}, 32'(n), 32'(DELAY + 1));
      chk({nm, " R6 flag set"}, 32'(req_flag[0]), 32'h1);
      chk({nm, " R8 svc follows enable"}, 32'(svc_req[0]), 32'(en));
      chk({nm, " R6 single wake pulse"}, 32'(wake_cnt), 32'h1);
      if (!en) begin
         wait_cyc(4);
         chk({nm, " R8 flag kept"}, 32'(req_flag[0]), 32'h1);
      end
      clear_all();
      irq_en = 8'h00;
   endtask

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cfg_rw();
      t_edges();
      t_set_clr();
      t_refuse();
      t_wake("rise", 2'b01, 1'b0, 1'b1, 1'b0);
      t_wake("fall", 2'b10, 1'b1, 1'b0, 1'b1);
      t_wake("any-lo", 2'b11, 1'b1, 1'b0, 1'b1);
      t_wake("any-hi", 2'b11, 1'b0, 1'b1, 1'b0);
      wait_cyc(2);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule